// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Engine

This block carries packet bytes between a host processor and a peripheral controller through one byte-wide shift register. The host owns two active-low handshake lines on its port B, transfer-in-progress and transfer-acknowledge. The block owns a third active-low line, transfer-request. It does not shift bits serially. Each host write to port B is compared with the previous one, and when the handshake pair has changed, one whole byte moves.

A direction level picks the mode. When the host sends, the byte the host left in the shift register is appended to a small outbound buffer. When the host receives, the next byte of an inbound packet is placed in the shift register. The block requests service with transfer-request. At the end of a host transfer it emits a one-cycle packet-complete pulse that carries the outbound byte count. Every byte moved, and every handshake event, raises a shift-register event flag that the host clears. The contents of a packet are not interpreted.

Top module: `hsk_byte_xfer`

## Requirements
- R1: After reset, treq_n is 1, sr_flag is 0, pkt_done is 0 and sr_rdata is 0. The stored previous handshake pair is treated as both lines deasserted.
- R2: Port B bit 5 is in-progress and bit 4 is acknowledge, both active low. With dir_h2d=1 and bit 5 written as 0, a port B write whose bits [5:4] differ from the previous write appends sr_rdata to the outbound buffer at the next index (from 0) and sets sr_flag. A write with an unchanged pair moves nothing and leaves sr_flag alone.
- R3: The outbound buffer holds OUT_DEPTH (16) bytes. Once it is full, further bytes are dropped, sr_flag is not set, and the stored bytes are kept.
- R4: With dir_h2d=0 and bit 5 written as 0, a pair change while unread inbound bytes remain loads the next inbound byte into sr_rdata and sets sr_flag. Loading the last byte drives treq_n to 1. When no byte is left, nothing changes.
- R5: When the previous write had bit 5 at 1, and the new write has bit 5 at 1 with bit 4 changed, treq_n takes the new bit 4 level and sr_flag is set.
- R6: A write with bit 5 at 1 after a write with bit 5 at 0 always sets sr_flag. If the outbound count is nonzero, pkt_done pulses for exactly one cycle with pkt_len equal to the count, and the count returns to 0. If the count is zero, there is no pulse.
- R7: On any write with bit 5 at 1 that is not the R5 case, treq_n is driven to 0 if unread inbound bytes remain.
- R8: An in_load strobe while the previous port B write had bit 5 at 1 sets the inbound length to in_len (capped at IN_DEPTH) and the read index to 0. It also sets sr_flag and drives treq_n to 0 when in_len is nonzero. While the previous write had bit 5 at 0, in_load and in_wr are ignored.
- R9: sr_flag_clr clears sr_flag, and an event that sets the flag in the same cycle wins.
- R10: sr_wr loads sr_wdata into sr_rdata. An inbound byte load in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_wr | input | 1 | Host port B write strobe |
| pb_wdata | input | 8 | Port B write value (bit 5 in-progress, bit 4 acknowledge) |
| dir_h2d | input | 1 | 1: host sends to device, 0: device sends to host |
| sr_wr | input | 1 | Host shift register write strobe |
| sr_wdata | input | 8 | Host shift register write value |
| sr_rdata | output | 8 | Shift register contents |
| sr_flag_clr | input | 1 | Clears the shift-register event flag |
| sr_flag | output | 1 | Shift-register event flag |
| treq_n | output | 1 | Transfer request, active low |
| in_wr | input | 1 | Inbound buffer byte write strobe |
| in_waddr | input | 7 | Inbound buffer write address |
| in_wdata | input | 8 | Inbound buffer write byte |
| in_load | input | 1 | Start a new inbound packet |
| in_len | input | 8 | Inbound packet length in bytes |
| out_raddr | input | 4 | Outbound buffer read address |
| out_rdata | output | 8 | Outbound buffer byte at out_raddr |
| pkt_done | output | 1 | One-cycle packet-complete pulse |
| pkt_len | output | 5 | Outbound byte count carried with pkt_done |

## Verification
The assertions watch, on every cycle, that pkt_done is a one-cycle pulse with a nonzero length no larger than the buffer. They also check that sr_flag, treq_n and sr_rdata change only in the cycle after a port B write, a shift register write or an inbound load. Which byte lands where, the dropping of bytes once the outbound buffer is full, treq_n rising after the last inbound byte and falling again while bytes remain unread, and loads ignored during a transfer are shown only by the bench's scenarios. Those scenarios compare the shift register, the outbound buffer and treq_n against sequences computed from the requirements.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  localparam int TREQ_BIT = 3;
  localparam int TACK_BIT = 4;
  localparam int TIP_BIT  = 5;

  typedef struct packed {
    logic push_out;
    logic pop_in;
    logic pkt_end;
    logic flag_set;
    logic treq_we;
    logic treq_val;
  } hbx_evt_t;
endpackage

// File: rtl/hbx_hsk_decode.sv
module hbx_hsk_decode
  import hbx_pkg::*;
(
  input  logic     strobe,
  input  logic     new_tack_n,
  input  logic     new_tip_n,
  input  logic     last_tack_n,
  input  logic     last_tip_n,
  input  logic     dir_h2d,
  input  logic     in_avail,
  input  logic     in_last,
  input  logic     out_full,
  input  logic     out_nonzero,
  output hbx_evt_t evt
);
  logic pair_chg;
  logic tack_chg;

  assign pair_chg = {new_tack_n, new_tip_n} != {last_tack_n, last_tip_n};
  assign tack_chg = new_tack_n != last_tack_n;

  always_comb begin
    evt = '0;
    if (strobe) begin
      if (!new_tip_n) begin
        if (dir_h2d) begin
          if (pair_chg && !out_full) begin
            evt.push_out = 1'b1;
            evt.flag_set = 1'b1;
          end
        end else if (pair_chg && in_avail) begin
          evt.pop_in   = 1'b1;
          evt.flag_set = 1'b1;
          if (in_last) begin
            evt.treq_we  = 1'b1;
            evt.treq_val = 1'b1;
          end
        end
      end else if (last_tip_n && tack_chg) begin
        evt.treq_we  = 1'b1;
        evt.treq_val = new_tack_n;
        evt.flag_set = 1'b1;
      end else begin
        if (!last_tip_n) begin
          evt.flag_set = 1'b1;
          evt.pkt_end  = out_nonzero;
        end
        if (in_avail) begin
          evt.treq_we  = 1'b1;
          evt.treq_val = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hbx_in_store.sv
module hbx_in_store #(
  parameter int DW       = 8,
  parameter int IN_DEPTH = 128,
  localparam int IN_AW   = $clog2(IN_DEPTH),
  localparam int IN_LW   = $clog2(IN_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             wr,
  input  logic [IN_AW-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             load,
  input  logic [IN_LW-1:0] len_in,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic             avail,
  output logic             last
);
  logic [DW-1:0]    mem [IN_DEPTH];
  logic [IN_LW-1:0] len_q, len_d;
  logic [IN_LW-1:0] idx_q, idx_d;
  logic [IN_LW-1:0] idx_inc;
  logic             ld_ok;

  assign ld_ok   = load && !lock;
  assign idx_inc = idx_q + IN_LW'(1);
  assign avail   = idx_q < len_q;
  assign last    = idx_inc == len_q;
  assign rdata   = mem[idx_q[IN_AW-1:0]];

  always_comb begin
    len_d = len_q;
    idx_d = idx_q;
    if (pop) idx_d = idx_inc;
    if (ld_ok) begin
      len_d = (len_in > IN_LW'(IN_DEPTH)) ? IN_LW'(IN_DEPTH) : len_in;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
    end else begin
      len_q <= len_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !lock) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/hbx_out_store.sv
module hbx_out_store #(
  parameter int DW        = 8,
  parameter int OUT_DEPTH = 16,
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DW-1:0]     wdata,
  input  logic              clear,
  input  logic [OUT_AW-1:0] raddr,
  output logic [DW-1:0]     rdata,
  output logic [OUT_CW-1:0] cnt,
  output logic              full,
  output logic              nonzero
);
  logic [DW-1:0]     mem [OUT_DEPTH];
  logic [OUT_CW-1:0] cnt_q, cnt_d;

  assign cnt     = cnt_q;
  assign full    = cnt_q == OUT_CW'(OUT_DEPTH);
  assign nonzero = cnt_q != '0;
  assign rdata   = mem[raddr];

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full) cnt_d = cnt_q + OUT_CW'(1);
    if (clear)         cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt_q[OUT_AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/hsk_byte_xfer.sv
module hsk_byte_xfer
  import hbx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int IN_DEPTH  = 128,
  parameter int OUT_DEPTH = 16,
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int IN_LW    = $clog2(IN_DEPTH + 1),
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_wr,
  input  logic [7:0]        pb_wdata,
  input  logic              dir_h2d,
  input  logic              sr_wr,
  input  logic [DW-1:0]     sr_wdata,
  output logic [DW-1:0]     sr_rdata,
  input  logic              sr_flag_clr,
  output logic              sr_flag,
  output logic              treq_n,
  input  logic              in_wr,
  input  logic [IN_AW-1:0]  in_waddr,
  input  logic [DW-1:0]     in_wdata,
  input  logic              in_load,
  input  logic [IN_LW-1:0]  in_len,
  input  logic [OUT_AW-1:0] out_raddr,
  output logic [DW-1:0]     out_rdata,
  output logic              pkt_done,
  output logic [OUT_CW-1:0] pkt_len
);
  hbx_evt_t          evt;
  logic              last_tack_q, last_tack_d;
  logic              last_tip_q, last_tip_d;
  logic [DW-1:0]     sr_q, sr_d;
  logic              flag_q, flag_d;
  logic              treq_q, treq_d;
  logic              done_q, done_d;
  logic [OUT_CW-1:0] len_q, len_d;
  logic [DW-1:0]     in_rdata;
  logic              in_avail, in_last;
  logic [OUT_CW-1:0] out_cnt;
  logic              out_full, out_nonzero;
  logic              lock;
  logic              load_ok;

  assign lock    = !last_tip_q;
  assign load_ok = in_load && !lock;

  hbx_hsk_decode u_dec (
    .strobe      (pb_wr),
    .new_tack_n  (pb_wdata[TACK_BIT]),
    .new_tip_n   (pb_wdata[TIP_BIT]),
    .last_tack_n (last_tack_q),
    .last_tip_n  (last_tip_q),
    .dir_h2d     (dir_h2d),
    .in_avail    (in_avail),
    .in_last     (in_last),
    .out_full    (out_full),
    .out_nonzero (out_nonzero),
    .evt         (evt)
  );

  hbx_in_store #(.DW(DW), .IN_DEPTH(IN_DEPTH)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock   (lock),
    .wr     (in_wr),
    .waddr  (in_waddr),
    .wdata  (in_wdata),
    .load   (in_load),
    .len_in (in_len),
    .pop    (evt.pop_in),
    .rdata  (in_rdata),
    .avail  (in_avail),
    .last   (in_last)
  );

  hbx_out_store #(.DW(DW), .OUT_DEPTH(OUT_DEPTH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (evt.push_out),
    .wdata   (sr_q),
    .clear   (evt.pkt_end),
    .raddr   (out_raddr),
    .rdata   (out_rdata),
    .cnt     (out_cnt),
    .full    (out_full),
    .nonzero (out_nonzero)
  );

  always_comb begin
    last_tack_d = last_tack_q;
    last_tip_d  = last_tip_q;
    if (pb_wr) begin
      last_tack_d = pb_wdata[TACK_BIT];
      last_tip_d  = pb_wdata[TIP_BIT];
    end

    sr_d = sr_q;
    if (sr_wr)      sr_d = sr_wdata;
    if (evt.pop_in) sr_d = in_rdata;

    flag_d = flag_q;
    if (sr_flag_clr)              flag_d = 1'b0;
    if (evt.flag_set || load_ok)  flag_d = 1'b1;

    treq_d = treq_q;
    if (evt.treq_we)                  treq_d = evt.treq_val;
    else if (load_ok && in_len != '0) treq_d = 1'b0;

    done_d = evt.pkt_end;
    len_d  = evt.pkt_end ? out_cnt : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tack_q <= 1'b1;
      last_tip_q  <= 1'b1;
      sr_q        <= '0;
      flag_q      <= 1'b0;
      treq_q      <= 1'b1;
      done_q      <= 1'b0;
      len_q       <= '0;
    end else begin
      last_tack_q <= last_tack_d;
      last_tip_q  <= last_tip_d;
      sr_q        <= sr_d;
      flag_q      <= flag_d;
      treq_q      <= treq_d;
      done_q      <= done_d;
      len_q       <= len_d;
    end
  end

  assign sr_rdata = sr_q;
  assign sr_flag  = flag_q;
  assign treq_n   = treq_q;
  assign pkt_done = done_q;
  assign pkt_len  = len_q;
endmodule

// File: rtl/hbx_xfer_chk.sv
module hbx_xfer_chk #(
  parameter int DW        = 8,
  parameter int OUT_DEPTH = 16,
  localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pb_wr,
  input logic              sr_wr,
  input logic              in_load,
  input logic [DW-1:0]     sr_rdata,
  input logic              sr_flag,
  input logic              treq_n,
  input logic              pkt_done,
  input logic [OUT_CW-1:0] pkt_len
);
  AST_PKT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R6

  AST_PKT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> pkt_len != '0); // R6

  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> pkt_len <= OUT_CW'(OUT_DEPTH)); // R3

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_flag) |-> $past(pb_wr || in_load)); // R2

  AST_TREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(treq_n) |-> $past(pb_wr || in_load)); // R5

  AST_SR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr_rdata) |-> $past(pb_wr || sr_wr)); // R10
endmodule

bind hsk_byte_xfer hbx_xfer_chk #(.DW(DW), .OUT_DEPTH(OUT_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pb_wr    (pb_wr),
  .sr_wr    (sr_wr),
  .in_load  (in_load),
  .sr_rdata (sr_rdata),
  .sr_flag  (sr_flag),
  .treq_n   (treq_n),
  .pkt_done (pkt_done),
  .pkt_len  (pkt_len)
);

// File: tb/hsk_byte_xfer_tb.sv
`timescale 1ns/1ps
module hsk_byte_xfer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pb_wr, dir_h2d, sr_wr, sr_flag_clr, in_wr, in_load;
  logic [7:0] pb_wdata, sr_wdata, in_wdata, in_len;
  logic [6:0] in_waddr;
  logic [3:0] out_raddr;
  logic [7:0] sr_rdata, out_rdata;
  logic       sr_flag, treq_n, pkt_done;
  logic [4:0] pkt_len;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  logic       seen_pkt;
  logic [4:0] seen_len;

  always #4 clk = ~clk;

  hsk_byte_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .dir_h2d(dir_h2d), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .sr_flag_clr(sr_flag_clr), .sr_flag(sr_flag), .treq_n(treq_n),
    .in_wr(in_wr), .in_waddr(in_waddr), .in_wdata(in_wdata),
    .in_load(in_load), .in_len(in_len), .out_raddr(out_raddr),
    .out_rdata(out_rdata), .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  // {port B value, sr preset, exp treq_n, exp flag, exp pkt_done, exp pkt_len}
  localparam logic [23:0] TBL [8] = '{
    {8'h30, 8'hA1, 1'b1, 1'b0, 1'b0, 5'd0},
    {8'h10, 8'hA1, 1'b1, 1'b1, 1'b0, 5'd0},
    {8'h00, 8'hB2, 1'b1, 1'b1, 1'b0, 5'd0},
    {8'h00, 8'hC3, 1'b1, 1'b0, 1'b0, 5'd0},
    {8'h10, 8'hC3, 1'b1, 1'b1, 1'b0, 5'd0},
    {8'h30, 8'hC3, 1'b1, 1'b1, 1'b1, 5'd3},
    {8'h20, 8'hC3, 1'b0, 1'b1, 1'b0, 5'd0},
    {8'h30, 8'hC3, 1'b1, 1'b1, 1'b0, 5'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pb(input logic [7:0] v);
    @(negedge clk); pb_wr = 1'b1; pb_wdata = v;
    @(negedge clk); pb_wr = 1'b0;
    seen_pkt = pkt_done; seen_len = pkt_len;
  endtask

  task automatic clrf();
    @(negedge clk); sr_flag_clr = 1'b1;
    @(negedge clk); sr_flag_clr = 1'b0;
  endtask

  task automatic setsr(input logic [7:0] v);
    @(negedge clk); sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_wr = 1'b1; in_waddr = 7'(i); in_wdata = base + 8'(i * 8'h11);
    end
    @(negedge clk); in_wr = 1'b0; in_load = 1'b1; in_len = n;
    @(negedge clk); in_load = 1'b0;
  endtask

  function automatic int rdout(input int a);
    return 0;
  endfunction

  initial begin
    #1500000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pb_wr = 0; pb_wdata = 8'h30; dir_h2d = 1'b1; sr_wr = 0;
    sr_wdata = 0; sr_flag_clr = 0; in_wr = 0; in_waddr = 0; in_wdata = 0;
    in_load = 0; in_len = 0; out_raddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 treq_n", treq_n, 1);
    check("R1 sr_flag", sr_flag, 0);
    check("R1 pkt_done", pkt_done, 0);
    check("R1 sr_rdata", sr_rdata, 0);

    // R2 R5 R6 host-to-device table
    for (int i = 0; i < 8; i++) begin
      clrf();
      setsr(TBL[i][15:8]);
      pb(TBL[i][23:16]);
      check($sformatf("R2 step%0d treq_n", i), treq_n, TBL[i][7]);
      check($sformatf("R2 step%0d flag", i), sr_flag, TBL[i][6]);
      check($sformatf("R6 step%0d pkt_done", i), seen_pkt, TBL[i][5]);
      if (TBL[i][5]) check($sformatf("R6 step%0d pkt_len", i), seen_len, TBL[i][4:0]);
    end
    @(negedge clk);
    check("R6 pulse single", pkt_done, 0);
    for (int a = 0; a < 3; a++) begin
      out_raddr = 4'(a); #1;
      check("R2 outbound byte", out_rdata, (a == 0) ? 8'hA1 : (a == 1) ? 8'hB2 : 8'hC3);
    end

    // R3 overflow
    for (int i = 0; i < 18; i++) begin
      clrf();
      setsr(8'(i));
      pb((i % 2 == 0) ? 8'h10 : 8'h00);
      if (i >= 16) check("R3 flag after full", sr_flag, 0);
    end
    out_raddr = 4'd0; #1; check("R3 byte0", out_rdata, 0);
    out_raddr = 4'd15; #1; check("R3 byte15 kept", out_rdata, 15);
    pb(8'h30);
    check("R3 pkt_len capped", seen_len, 16);
    check("R6 pkt_done full", seen_pkt, 1);

    // R4 device-to-host
    dir_h2d = 1'b0;
    clrf();
    load(3, 8'h11);
    check("R8 load flag", sr_flag, 1);
    check("R8 load treq_n", treq_n, 0);
    clrf(); pb(8'h10);
    check("R4 byte0", sr_rdata, 8'h11); check("R4 flag0", sr_flag, 1); check("R4 treq mid", treq_n, 0);
    clrf(); pb(8'h00);
    check("R4 byte1", sr_rdata, 8'h22);
    clrf(); pb(8'h10);
    check("R4 byte2", sr_rdata, 8'h33); check("R4 treq after last", treq_n, 1);
    clrf(); pb(8'h00);
    check("R4 exhausted sr", sr_rdata, 8'h33); check("R4 exhausted flag", sr_flag, 0);
    clrf(); pb(8'h30);
    check("R6 end flag", sr_flag, 1); check("R6 no pulse empty", seen_pkt, 0);
    check("R7 none unread", treq_n, 1);

    // R8 load ignored during transfer
    clrf(); pb(8'h10);
    load(2, 8'h77);
    check("R8 ignored flag", sr_flag, 0);
    check("R8 ignored treq", treq_n, 1);
    pb(8'h30);
    check("R8 ignored len", treq_n, 1);

    // R7 reassert with unread bytes
    load(2, 8'h55);
    clrf(); pb(8'h10);
    check("R4 reload byte0", sr_rdata, 8'h55);
    pb(8'h30); check("R7 end unread", treq_n, 0);
    clrf(); pb(8'h20);
    check("R5 copy low", treq_n, 0); check("R5 flag", sr_flag, 1);
    pb(8'h30); check("R5 copy high", treq_n, 1);
    pb(8'h30); check("R7 reassert", treq_n, 0);

    // R9 R10
    clrf(); check("R9 clear", sr_flag, 0);
    setsr(8'h5A); check("R10 host write", sr_rdata, 8'h5A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule